// File: doc/BRIEF.md
# Pipelined Set-Associative Read Cache

This block is a small read-only first-level cache that sits in front of a word-addressed backing bus. Requests arrive on a stage-1 interface and are resolved one stage later. Stage 2 looks up the tag store and reports a hit or a miss. On a hit it returns the word. It also carries out whole-cache flush commands, which it acknowledges, and single-line evict commands.

When a read misses, the block fetches the whole line from the backing bus as an in-order burst of words. It holds stage 1 until the burst finishes, and then the same read completes as a hit. The number of ways, lines per way and words per line are parameters. Every address in the `AW`-bit word address space is cacheable. Writes are not supported.

Top module: `ro_cache`

## Requirements
- R1: Stage 2 captures the stage-1 command and address only in cycles where `req_hold` is low. While `req_hold` is high, stage 2 keeps its operation and stage-1 inputs are ignored.
- R2: `req_hold` is high exactly while stage 2 holds either a valid flush that has not yet been acknowledged or a valid read that misses.
- R3: A stage-2 read that hits (`rsp_miss` low) presents on `rsp_data` the word the backing bus holds at that address, in the same cycle.
- R4: A flush clears every line in its first stage-2 cycle. `flush_done` goes high in the next cycle, for one cycle, and the flush then leaves stage 2. After that, reads miss until lines are refilled.
- R5: A valid read whose line is absent raises `rsp_miss`. A line becomes valid only on a beat with `fill_req`, `fill_vld` and `fill_end` high and `fill_err` low. In the cycle after that beat, the stalled read hits, and later reads of that line hit until a flush or evict removes it.
- R6: A valid evict removes the line matching its tag and index, if there is one, without stalling. A later read of that line misses and triggers a refill. An evict with no matching line changes nothing.
- R7: A word address splits into fields: bits [OW-1:0] are the word offset, the next IW bits are the line index, and the top bits are the tag. OW = log2(WORDS) and IW = log2(LINES).
- R8: A refill drives `fill_req` high from the cycle after the miss is seen until the beat that carries `fill_end`. `fill_addr` walks the missing line's words from offset 0 upward, and advances only on beats with `fill_vld` high.
- R9: If the final beat carries `fill_err`, the line stays invalid. The waiting read still misses, and a new burst for the same line starts in the next cycle.
- R10: With several ways, each line index has a round-robin pointer that picks the way to refill and advances after each successful refill. Two valid ways of one set never hold the same tag.
- R11: After reset, stage 2 is empty, every line is invalid, and `req_hold`, `rsp_miss`, `flush_done` and `fill_req` are low.
- R12: When several command bits are set together, flush wins over evict and evict wins over read. A request with `req_valid` low enters stage 2 as an empty slot whatever its command bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Stage-1 request present |
| req_addr | input | AW | Stage-1 word address |
| req_rd | input | 1 | Stage-1 read command |
| req_flush | input | 1 | Stage-1 flush command |
| req_evict | input | 1 | Stage-1 evict command |
| req_hold | output | 1 | Stage 1 must hold its request |
| rsp_miss | output | 1 | Stage-2 read misses |
| rsp_data | output | DW | Stage-2 read data on a hit |
| flush_done | output | 1 | Stage-2 flush acknowledged |
| fill_req | output | 1 | Refill burst in progress |
| fill_addr | output | AW | Word address of the current refill beat |
| fill_data | input | DW | Refill beat data |
| fill_vld | input | 1 | Refill beat valid |
| fill_end | input | 1 | Last beat of the burst |
| fill_err | input | 1 | Burst error, taken from the last beat |

## Verification
The bench builds the block with two ways, two lines per way and four words per line over a 64-word address space. With these values a single index can be shared by three tags, so the round-robin victim choice replaces a specific, predictable line. With only two sets, flush, evict and refill land on the same lines often enough to collide. The reference model follows the cache contents, the stage-2 slot and the burst progress each cycle. Directed sequences add bus gaps, a failed burst followed by a retry, requests that change during a stall, and commands with several bits set at once.

// File: rtl/ro_cache_pkg.sv
package ro_cache_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_FLUSH = 2'd2,
    CMD_EVICT = 2'd3
  } cmd_e;

  // flush outranks evict, evict outranks read; an invalid slot is idle
  function automatic cmd_e decode_cmd(input logic v, input logic rd,
                                      input logic fl, input logic ev);
    cmd_e c;
    c = CMD_IDLE;
    if (v) begin
      if (fl)      c = CMD_FLUSH;
      else if (ev) c = CMD_EVICT;
      else if (rd) c = CMD_READ;
    end
    return c;
  endfunction

endpackage

// File: rtl/ro_cache_tags.sv
module ro_cache_tags #(
  parameter int WAYS  = 2,
  parameter int LINES = 2,
  parameter int TW    = 3,
  parameter int IW    = 1,
  parameter int WW    = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   lk_idx,
  input  logic [TW-1:0]   lk_tag,
  output logic [WAYS-1:0] hit_vec,
  output logic            hit,
  output logic            any_valid,
  output logic [WW-1:0]   victim,
  input  logic            flush_all,
  input  logic            evict_en,
  input  logic            clr_en,
  input  logic            set_en,
  input  logic [WW-1:0]   set_way,
  input  logic [IW-1:0]   set_idx,
  input  logic [TW-1:0]   set_tag
);

  logic [LINES-1:0][WAYS-1:0]         valid_q, valid_d;
  logic [LINES-1:0][WAYS-1:0][TW-1:0] tag_q, tag_d;
  logic [LINES-1:0][WW-1:0]           rr_q, rr_d;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_idx][w] & (tag_q[lk_idx][w] == lk_tag);
  end

  assign hit       = |hit_vec;
  assign any_valid = |valid_q;
  assign victim    = rr_q[lk_idx];

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    rr_d    = rr_q;
    if (flush_all) valid_d = '0;
    if (evict_en)  valid_d[lk_idx] = valid_q[lk_idx] & ~hit_vec;
    if (clr_en)    valid_d[lk_idx][victim] = 1'b0;
    if (set_en) begin
      valid_d[set_idx][set_way] = 1'b1;
      tag_d[set_idx][set_way]   = set_tag;
      rr_d[set_idx] = (set_way == WW'(WAYS-1)) ? '0 : set_way + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      rr_q    <= rr_d;
    end
  end

  // R10: no set may hold the same tag twice
  for (genvar l = 0; l < LINES; l++) begin : g_dup_l
    for (genvar i = 0; i < WAYS; i++) begin : g_dup_i
      for (genvar j = i + 1; j < WAYS; j++) begin : g_dup_j
        p_no_dup_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
          !(valid_q[l][i] && valid_q[l][j] && (tag_q[l][i] == tag_q[l][j])));
      end
    end
  end

  // R10: a lookup never matches two ways at once
  p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/ro_cache_data.sv
module ro_cache_data #(
  parameter int WAYS  = 2,
  parameter int LINES = 2,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int IW    = 1,
  parameter int OW    = 2,
  parameter int WW    = 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [WW-1:0]   wr_way,
  input  logic [IW-1:0]   wr_idx,
  input  logic [OW-1:0]   wr_off,
  input  logic [DW-1:0]   wr_data,
  input  logic [IW-1:0]   rd_idx,
  input  logic [OW-1:0]   rd_off,
  input  logic [WAYS-1:0] rd_sel,
  output logic [DW-1:0]   rd_data
);

  localparam int PW    = WW + IW + OW;
  localparam int DEPTH = 1 << PW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_way, wr_idx, wr_off}] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_sel[w]) rd_data = rd_data | mem_q[{WW'(w), rd_idx, rd_off}];
    end
  end

endmodule

// File: rtl/ro_cache_fill.sv
module ro_cache_fill #(
  parameter int AW = 6,
  parameter int OW = 2,
  parameter int IW = 1,
  parameter int TW = 3,
  parameter int WW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] st_idx,
  input  logic [TW-1:0] st_tag,
  input  logic [WW-1:0] st_way,
  input  logic          beat_vld,
  input  logic          beat_end,
  input  logic          beat_err,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [WW-1:0] wr_way,
  output logic [IW-1:0] wr_idx,
  output logic [OW-1:0] wr_off,
  output logic          done_ok,
  output logic          done_err
);

  logic          busy_q, busy_d;
  logic [OW-1:0] beat_q, beat_d;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] tag_q;
  logic [WW-1:0] way_q;
  logic          take, last;

  assign take = busy_q & beat_vld;
  assign last = take & beat_end;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    if (start) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else begin
      if (take) beat_d = beat_q + OW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      idx_q  <= '0;
      tag_q  <= '0;
      way_q  <= '0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      if (start) begin
        idx_q <= st_idx;
        tag_q <= st_tag;
        way_q <= st_way;
      end
    end
  end

  assign busy     = busy_q;
  assign rd_addr  = {tag_q, idx_q, beat_q};
  assign wr_en    = take;
  assign wr_way   = way_q;
  assign wr_idx   = idx_q;
  assign wr_off   = beat_q;
  assign done_ok  = last & ~beat_err;
  assign done_err = last & beat_err;

  // R8: every burst begins at word offset zero
  p_burst_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (beat_q == '0));

  // R8: the request drops right after the final beat
  p_burst_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && beat_vld && beat_end) |=> !busy_q);

endmodule

// File: rtl/ro_cache.sv
module ro_cache
  import ro_cache_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int LINES = 2,
  parameter int WORDS = 4,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rd,
  input  logic          req_flush,
  input  logic          req_evict,
  output logic          req_hold,
  output logic          rsp_miss,
  output logic [DW-1:0] rsp_data,
  output logic          flush_done,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          fill_vld,
  input  logic          fill_end,
  input  logic          fill_err
);

  localparam int OW = $clog2(WORDS);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - OW - IW;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  // stage-2 slot
  logic          st_valid_q, st_valid_d;
  cmd_e          st_cmd_q, st_cmd_d;
  logic [AW-1:0] st_addr_q, st_addr_d;
  logic          st_load;
  logic          ack_q, ack_d;

  logic [OW-1:0] st_off;
  logic [IW-1:0] st_idx;
  logic [TW-1:0] st_tag;
  logic          is_rd, is_fl, is_ev;

  logic [WAYS-1:0] hit_vec;
  logic            hit, any_valid;
  logic [WW-1:0]   victim;
  logic            flush_all, fill_start;

  logic          fill_busy, wr_en, done_ok, done_err;
  logic [WW-1:0] wr_way;
  logic [IW-1:0] wr_idx;
  logic [OW-1:0] wr_off;

  assign st_off = st_addr_q[OW-1:0];
  assign st_idx = st_addr_q[OW +: IW];
  assign st_tag = st_addr_q[AW-1 -: TW];

  assign is_rd = st_valid_q & (st_cmd_q == CMD_READ);
  assign is_fl = st_valid_q & (st_cmd_q == CMD_FLUSH);
  assign is_ev = st_valid_q & (st_cmd_q == CMD_EVICT);

  assign rsp_miss   = is_rd & ~hit;
  assign req_hold   = (is_fl & ~ack_q) | rsp_miss;
  assign flush_all  = is_fl & ~ack_q;
  assign fill_start = rsp_miss & ~fill_busy;
  assign st_load    = ~req_hold;

  always_comb begin
    st_valid_d = req_valid;
    st_cmd_d   = decode_cmd(req_valid, req_rd, req_flush, req_evict);
    st_addr_d  = req_addr;
    ack_d      = flush_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_cmd_q   <= CMD_IDLE;
      st_addr_q  <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= ack_d;
      if (st_load) begin
        st_valid_q <= st_valid_d;
        st_cmd_q   <= st_cmd_d;
        st_addr_q  <= st_addr_d;
      end
    end
  end

  assign flush_done = ack_q;
  assign fill_req   = fill_busy;

  ro_cache_tags #(.WAYS(WAYS), .LINES(LINES), .TW(TW), .IW(IW), .WW(WW)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (st_idx),
    .lk_tag    (st_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .any_valid (any_valid),
    .victim    (victim),
    .flush_all (flush_all),
    .evict_en  (is_ev),
    .clr_en    (fill_start),
    .set_en    (done_ok),
    .set_way   (wr_way),
    .set_idx   (wr_idx),
    .set_tag   (fill_addr[AW-1 -: TW])
  );

  ro_cache_data #(.WAYS(WAYS), .LINES(LINES), .WORDS(WORDS), .DW(DW),
                  .IW(IW), .OW(OW), .WW(WW)) u_data (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_way  (wr_way),
    .wr_idx  (wr_idx),
    .wr_off  (wr_off),
    .wr_data (fill_data),
    .rd_idx  (st_idx),
    .rd_off  (st_off),
    .rd_sel  (hit_vec),
    .rd_data (rsp_data)
  );

  ro_cache_fill #(.AW(AW), .OW(OW), .IW(IW), .TW(TW), .WW(WW)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fill_start),
    .st_idx   (st_idx),
    .st_tag   (st_tag),
    .st_way   (victim),
    .beat_vld (fill_vld),
    .beat_end (fill_end),
    .beat_err (fill_err),
    .busy     (fill_busy),
    .rd_addr  (fill_addr),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_idx   (wr_idx),
    .wr_off   (wr_off),
    .done_ok  (done_ok),
    .done_err (done_err)
  );

  // R1: a held stage keeps its operation
  p_hold_keeps_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_hold |=> ($stable(st_valid_q) && $stable(st_cmd_q) && $stable(st_addr_q)));

  // R4: acknowledge only after the tag store is empty
  p_ack_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_done) |-> !any_valid);

  // R4: acknowledge only while a flush sits in stage 2
  p_ack_with_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> is_fl);

  // R5: the waiting read hits right after a clean final beat
  p_hit_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !rsp_miss);

  // R9: a failed burst leaves the waiting read missing
  p_miss_after_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> rsp_miss);

endmodule

// File: tb/ro_cache_tb_top.sv
module ro_cache_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 2;
  localparam int LINES = 2;
  localparam int WORDS = 4;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int WDOG  = 20000;

  logic          clk, rst_n;
  logic          req_valid, req_rd, req_flush, req_evict;
  logic [AW-1:0] req_addr;
  logic          req_hold, rsp_miss, flush_done, fill_req;
  logic [DW-1:0] rsp_data, fill_data;
  logic [AW-1:0] fill_addr;
  logic          fill_vld, fill_end, fill_err;

  ro_cache #(.WAYS(WAYS), .LINES(LINES), .WORDS(WORDS), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_rd(req_rd),
    .req_flush(req_flush), .req_evict(req_evict), .req_hold(req_hold),
    .rsp_miss(rsp_miss), .rsp_data(rsp_data), .flush_done(flush_done),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_vld(fill_vld), .fill_end(fill_end), .fill_err(fill_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int bursts = 0;
  bit prev_req = 0;
  bit finished = 0;

  // reference model state
  bit mv [WAYS][LINES];
  int mt [WAYS][LINES];
  int mrr [LINES];
  bit ms_v, mack, mbusy;
  int ms_cmd, ms_a, mbeat, mway;
  bit gap_mode, err_arm;

  function automatic logic [DW-1:0] memw(int a);
    return 32'h3C00_0000 + 32'(a) * 32'h0001_0203 ^ 32'h0000_0055;
  endfunction
  function automatic int f_idx(int a); return (a / WORDS) % LINES; endfunction
  function automatic int f_tag(int a); return a / (WORDS * LINES); endfunction

  function automatic int m_hitway();
    int hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (mv[w][f_idx(ms_a)] && mt[w][f_idx(ms_a)] == f_tag(ms_a)) hw = w;
    return hw;
  endfunction
  function automatic bit m_miss();
    return ms_v && ms_cmd == 1 && m_hitway() < 0;
  endfunction
  function automatic bit m_stall();
    return (ms_v && ms_cmd == 2 && !mack) || m_miss();
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic step();
    int ia = f_idx(ms_a);
    int ta = f_tag(ms_a);
    int hw = m_hitway();
    bit miss = m_miss();
    bit stall = m_stall();
    int ea = ta * WORDS * LINES + ia * WORDS + mbeat;
    bit bv;
    chk(req_hold == stall, "R2 req_hold", 64'(req_hold), 64'(stall));
    chk(rsp_miss == miss, "R5 rsp_miss", 64'(rsp_miss), 64'(miss));
    chk(flush_done == mack, "R4 flush_done", 64'(flush_done), 64'(mack));
    chk(fill_req == mbusy, "R8 fill_req", 64'(fill_req), 64'(mbusy));
    if (mbusy) chk(fill_addr == AW'(ea), "R8 fill_addr", 64'(fill_addr), 64'(ea));
    if (ms_v && ms_cmd == 1 && hw >= 0)
      chk(rsp_data == memw(ms_a), "R3 rsp_data", 64'(rsp_data), 64'(memw(ms_a)));
    if (fill_req && !prev_req) bursts++;
    prev_req = fill_req;
    // backing bus
    bv = mbusy && (!gap_mode || (cyc % 2 == 1));
    fill_vld  = bv;
    fill_end  = bv && (mbeat == WORDS - 1);
    fill_err  = fill_end && err_arm;
    fill_data = bv ? memw(ea) : '0;
    // model next state
    if (ms_v && ms_cmd == 2 && !mack) begin
      for (int w = 0; w < WAYS; w++) for (int l = 0; l < LINES; l++) mv[w][l] = 0;
    end
    mack = ms_v && ms_cmd == 2 && !mack;
    if (ms_v && ms_cmd == 3 && hw >= 0) mv[hw][ia] = 0;
    if (!mbusy && miss) begin
      mbusy = 1; mbeat = 0; mway = mrr[ia]; mv[mway][ia] = 0;
    end else if (mbusy && bv) begin
      if (fill_end) begin
        mbusy = 0;
        if (!err_arm) begin
          mv[mway][ia] = 1; mt[mway][ia] = ta; mrr[ia] = (mway + 1) % WAYS;
        end else err_arm = 0;
      end else mbeat++;
    end
    if (!stall) begin
      ms_v = req_valid;
      ms_cmd = !req_valid ? 0 : req_flush ? 2 : req_evict ? 3 : req_rd ? 1 : 0;
      ms_a = int'(req_addr);
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0; req_rd = 0; req_flush = 0; req_evict = 0;
  endtask

  task automatic drive(bit v, bit rd, bit fl, bit ev, int a);
    req_valid = v; req_rd = rd; req_flush = fl; req_evict = ev; req_addr = AW'(a);
  endtask

  task automatic issue(bit v, bit rd, bit fl, bit ev, int a);
    bit acc;
    drive(v, rd, fl, ev, a);
    do begin
      acc = !m_stall();
      step();
    end while (!acc);
    idle();
  endtask

  task automatic drain();
    idle();
    while (ms_v || mbusy) step();
  endtask

  // places a read in stage 2 and checks its first-cycle miss flag
  task automatic read_expect(int a, bit exp_miss, string tag);
    drain();
    drive(1, 1, 0, 0, a);
    step();
    idle();
    chk(rsp_miss == exp_miss, tag, 64'(rsp_miss), 64'(exp_miss));
    drain();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b0;
    rst_n = 0; idle(); req_addr = '0;
    fill_vld = 0; fill_end = 0; fill_err = 0; fill_data = '0;
    for (int w = 0; w < WAYS; w++) for (int l = 0; l < LINES; l++) begin
      mv[w][l] = 0; mt[w][l] = 0;
    end
    for (int l = 0; l < LINES; l++) mrr[l] = 0;
    ms_v = 0; mack = 0; mbusy = 0; ms_cmd = 0; ms_a = 0; mbeat = 0; mway = 0;
    gap_mode = 0; err_arm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(req_hold == 0, "R11 hold", 64'(req_hold), 0);
    chk(fill_req == 0, "R11 fill_req", 64'(fill_req), 0);
    chk(flush_done == 0, "R11 ack", 64'(flush_done), 0);
    chk(rsp_miss == 0, "R11 miss", 64'(rsp_miss), 0);

    // R5 / R7 field split, offset 1 index 1 tag 0
    read_expect(5, 1, "R5 cold miss");
    read_expect(6, 0, "R5 same line hit");
    read_expect(4, 0, "R7 offset field");
    read_expect(1, 1, "R7 index field");
    read_expect(13, 1, "R7 tag field");

    // R10 round robin on index 1: 5 in way0, 13 in way1, 21 replaces 5
    read_expect(5, 0, "R10 both ways kept");
    read_expect(21, 1, "R10 third tag misses");
    read_expect(13, 0, "R10 survivor hits");
    read_expect(5, 1, "R10 victim replaced");

    // R6 evict
    issue(1, 0, 0, 1, 21);
    read_expect(21, 1, "R6 evicted line misses");
    issue(1, 0, 0, 1, 29);
    read_expect(5, 0, "R6 no-match evict");

    // R8 bursts with gaps
    gap_mode = 1;
    read_expect(9, 1, "R8 gapped burst miss");
    read_expect(10, 0, "R8 gapped burst hit");
    gap_mode = 0;

    // R9 failing final beat then retry
    b0 = bursts;
    err_arm = 1;
    read_expect(33, 1, "R9 miss before error");
    chk(bursts - b0 == 2, "R9 retry burst count", 64'(bursts - b0), 2);
    read_expect(34, 0, "R9 hit after retry");

    // R4 flush
    drain();
    drive(1, 0, 1, 0, 0);
    step();
    idle();
    chk(req_hold == 1, "R2 flush holds", 64'(req_hold), 1);
    chk(flush_done == 0, "R4 ack not yet", 64'(flush_done), 0);
    step();
    chk(flush_done == 1, "R4 ack", 64'(flush_done), 1);
    chk(req_hold == 0, "R4 released", 64'(req_hold), 0);
    drain();
    read_expect(33, 1, "R4 empty after flush");
    read_expect(13, 1, "R4 other line empty");

    // R1 inputs ignored during a stall
    drain();
    drive(1, 1, 0, 0, 45);
    step();
    drive(1, 0, 1, 0, 0);
    repeat (3) step();
    chk(flush_done == 0, "R1 no flush captured", 64'(flush_done), 0);
    drain();
    read_expect(45, 0, "R1 line survives");

    // R12 priority and empty slots
    issue(1, 1, 1, 1, 45);
    read_expect(45, 1, "R12 flush wins");
    issue(1, 1, 0, 1, 45);
    read_expect(45, 1, "R12 evict wins over read");
    drain();
    drive(0, 1, 0, 0, 61);
    step();
    idle();
    chk(rsp_miss == 0, "R12 invalid slot no miss", 64'(rsp_miss), 0);
    step();
    chk(fill_req == 0, "R12 invalid slot no fill", 64'(fill_req), 0);
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule